// File: doc/BRIEF.md
# Associative Cache Victim-Way Selector

This block chooses which way of a set an N-way associative cache should overwrite on its next fill. The cache controller gives it the set being looked up, the per-way valid bits of that set, and strobes for each hit or fill along with the way involved. The block answers with a victim way for that set. It keeps a small amount of replacement history per set and updates it from those strobes. It does not hold tags or data, and it does not handle misses.

The replacement policy is fixed by a parameter when the design is elaborated. `POLICY=0` selects a binary-tree pseudo-LRU. With two ways this tree is a single bit per set, which makes it exact LRU. `POLICY=1` selects round-robin FIFO. `POLICY=2` selects not-recently-used: FIFO order, except that the way touched last is never picked. In every policy, an empty way in the set is chosen ahead of any policy decision. The victim is combinational from the current set index. A strobe changes the state at the next clock edge.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, the victim for every set is way 0 when all ways are valid, whatever the policy.
- R2: If any valid bit of the addressed set is 0, the victim is the lowest-numbered way whose valid bit is 0, in every policy.
- R3: Tree policy with 4 or 8 ways: each set keeps WAYS-1 node bits, stored heap-ordered (children of node n are 2n+1 and 2n+2; bit 0 steers to the lower half, bit 1 to the upper half). Every hit and every fill sets each node on the path of the accessed way to point away from it. The victim is found by walking the tree from node 0.
- R4: Tree policy with 2 ways: when all ways are valid, the victim is the way that was not accessed most recently by a hit or fill.
- R5: FIFO policy: a per-set pointer gives the victim. A fill to that set advances the pointer by one, wrapping modulo WAYS. Hits leave it unchanged.
- R6: Not-recently-used policy: the pointer advances as in R5. The last way accessed by a hit or fill is recorded per set. If the pointer equals that recorded way, the victim is the pointer plus one instead.
- R7: A hit or fill changes only the state of the set addressed in that cycle.
- R8: The victim depends combinationally on the current inputs. A strobe takes effect on the victim in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all per-set state |
| set_idx | input | $clog2(SETS) | Set being looked up or updated |
| acc_way | input | $clog2(WAYS) | Way hit or filled in this cycle |
| hit | input | 1 | A hit on acc_way in set_idx |
| fill | input | 1 | A fill of acc_way in set_idx; consumes a victim |
| valid | input | WAYS | Per-way valid bits of set set_idx |
| victim | output | $clog2(WAYS) | Way to replace in set set_idx |

## Verification
The victim is a combinational function of set_idx, valid and the stored state. It is therefore due in the same cycle the inputs are applied, and the bench samples it 1 ns after driving those inputs on the falling edge. A hit or fill is registered on the following rising edge, so its effect is due one cycle later. The bench's reference models apply each strobe only after the same-cycle compare, which keeps every compare aligned with that one-cycle delay. Four instances (tree with 4 ways, tree with 2 ways, FIFO, not-recently-used) share each stimulus cycle and are compared against their own models.

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int POLICY = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       set_idx,
  input  logic [$clog2(WAYS)-1:0]       acc_way,
  input  logic                          hit,
  input  logic                          fill,
  input  logic [WAYS-1:0]               valid,
  output logic [$clog2(WAYS)-1:0]       victim
);
  localparam int WW = $clog2(WAYS);

  logic [WW-1:0] inv_way, pol_way;
  wire full  = &valid;
  wire touch = hit | fill;

  always_comb begin
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid[i]) inv_way = WW'(i);
  end

  assign victim = full ? pol_way : inv_way;

  AST_INV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid[victim]); // R2

  generate
    if (POLICY == 0) begin : g_tree
      logic [WAYS-2:0] tree_q [SETS];
      logic [WAYS-2:0] cur, nxt;
      assign cur = tree_q[set_idx];

      always_comb begin
        int node;
        node = 0;
        pol_way = '0;
        for (int l = 0; l < WW; l++) begin
          pol_way[WW-1-l] = cur[node];
          node = 2 * node + 1 + int'(cur[node]);
        end
      end

      always_comb begin
        int node;
        node = 0;
        nxt = cur;
        for (int l = 0; l < WW; l++) begin
          nxt[node] = ~acc_way[WW-1-l];
          node = 2 * node + 1 + int'(acc_way[WW-1-l]);
        end
      end

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch) begin
          tree_q[set_idx] <= nxt;
        end

      AST_TREE_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && full) |=> (set_idx != $past(set_idx) || !full || victim != $past(acc_way))); // R3 R4

    end else if (POLICY == 1) begin : g_fifo
      logic [WW-1:0] ptr_q [SETS];
      assign pol_way = ptr_q[set_idx];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (fill) begin
          ptr_q[set_idx] <= ptr_q[set_idx] + 1'b1;
        end

      AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fill |=> ptr_q[$past(set_idx)] == $past(ptr_q[set_idx])); // R5
      AST_FIFO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> ptr_q[$past(set_idx)] == WW'($past(ptr_q[set_idx]) + 1'b1)); // R5

    end else begin : g_nru
      logic [WW-1:0] ptr_q  [SETS];
      logic [WW-1:0] last_q [SETS];
      logic [SETS-1:0] seen_q;
      wire [WW-1:0] ptr = ptr_q[set_idx];
      assign pol_way = (seen_q[set_idx] && ptr == last_q[set_idx]) ? ptr + 1'b1 : ptr;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) begin
            ptr_q[s]  <= '0;
            last_q[s] <= '0;
          end
          seen_q <= '0;
        end else begin
          if (fill) ptr_q[set_idx] <= ptr + 1'b1;
          if (touch) begin
            last_q[set_idx] <= acc_way;
            seen_q[set_idx] <= 1'b1;
          end
        end

      AST_NRU_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && seen_q[set_idx]) |-> victim != last_q[set_idx]); // R6
      AST_NRU_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> ptr_q[$past(set_idx)] == WW'($past(ptr) + 1'b1)); // R6
    end
  endgenerate
endmodule

// File: tb/way_victim_sel_test.sv
module way_victim_sel_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] set_idx = 0, acc_way = 0;
  logic hit = 0, fill = 0;
  logic [3:0] valid = 4'hF;
  logic [1:0] v_tree, v_fifo, v_nru;
  logic       v_lru2;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  way_victim_sel #(.WAYS(4), .SETS(4), .POLICY(0)) uut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_way(acc_way),
    .hit(hit), .fill(fill), .valid(valid), .victim(v_tree));
  way_victim_sel #(.WAYS(2), .SETS(4), .POLICY(0)) u_lru2 (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_way(acc_way[0:0]),
    .hit(hit), .fill(fill), .valid(valid[1:0]), .victim(v_lru2));
  way_victim_sel #(.WAYS(4), .SETS(4), .POLICY(1)) u_fifo (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_way(acc_way),
    .hit(hit), .fill(fill), .valid(valid), .victim(v_fifo));
  way_victim_sel #(.WAYS(4), .SETS(4), .POLICY(2)) u_nru (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_way(acc_way),
    .hit(hit), .fill(fill), .valid(valid), .victim(v_nru));

  logic [2:0] m_tree [4];
  logic       m_lru2 [4];
  logic [1:0] m_fptr [4], m_nptr [4], m_nlast [4];
  logic       m_nseen [4];

  function automatic logic [1:0] low_inv(input logic [3:0] v);
    for (int i = 3; i >= 0; i--) if (!v[i]) low_inv = 2'(i);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [1:0] s, input logic [1:0] w, input logic h,
                     input logic f, input logic [3:0] v, input string tag);
    logic [1:0] e4, ef, en;
    logic       e2;
    @(negedge clk);
    set_idx = s; acc_way = w; hit = h; fill = f; valid = v;
    #1;
    e4 = m_tree[s][0] ? {1'b1, m_tree[s][2]} : {1'b0, m_tree[s][1]};
    e2 = m_lru2[s];
    ef = m_fptr[s];
    en = (m_nseen[s] && m_nptr[s] == m_nlast[s]) ? m_nptr[s] + 2'd1 : m_nptr[s];
    if (&v) begin
      chk(tag == "" ? "R3 tree4" : tag, v_tree, e4);
      chk(tag == "" ? "R5 fifo" : tag, v_fifo, ef);
      chk(tag == "" ? "R6 nru" : tag, v_nru, en);
    end else begin
      chk(tag == "" ? "R2 tree4" : tag, v_tree, low_inv(v));
      chk(tag == "" ? "R2 fifo" : tag, v_fifo, low_inv(v));
      chk(tag == "" ? "R2 nru" : tag, v_nru, low_inv(v));
    end
    if (&v[1:0]) chk(tag == "" ? "R4 lru2" : tag, v_lru2, e2);
    else         chk(tag == "" ? "R2 lru2" : tag, v_lru2, v[0] ? 1 : 0);
    if (h || f) begin
      m_tree[s][0] = ~w[1];
      if (!w[1]) m_tree[s][1] = ~w[0]; else m_tree[s][2] = ~w[0];
      m_lru2[s] = ~w[0];
      m_nlast[s] = w;
      m_nseen[s] = 1'b1;
    end
    if (f) begin
      m_fptr[s] = m_fptr[s] + 2'd1;
      m_nptr[s] = m_nptr[s] + 2'd1;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    for (int s = 0; s < 4; s++) begin
      m_tree[s] = 0; m_lru2[s] = 0; m_fptr[s] = 0;
      m_nptr[s] = 0; m_nlast[s] = 0; m_nseen[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 4; s++) cyc(2'(s), 0, 0, 0, 4'hF, "R1 reset");
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 15; v++) cyc(2'(s), 0, 0, 0, 4'(v), "R2 sweep");
    cyc(1, 2, 1, 0, 4'hF, "");
    cyc(1, 0, 0, 0, 4'hF, "R8 next cycle");
    cyc(1, 1, 0, 1, 4'hF, "");
    cyc(1, 0, 0, 0, 4'hF, "R8 after fill");
    for (int k = 0; k < 6; k++) cyc(2, 2'(k), k[0], ~k[0], 4'hF, "");
    for (int s = 0; s < 4; s++) cyc(2'(s), 0, 0, 0, 4'hF, "R7 set isolation");
    for (int k = 0; k < 8; k++) cyc(3, 2'(k), 1, 0, 4'hF, "");
    cyc(3, 0, 0, 0, 4'hF, "R5 hits keep fifo");
    r = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      cyc(r[1:0], r[3:2], r[4] & ~r[5], r[5], (r[7:6] == 0) ? r[11:8] : 4'hF, "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule